// File: doc/BRIEF.md
# Instruction Fetch Sequencer

This block decides which instruction word a small 64-bit register machine runs next. Each cycle in which it is not holding, it presents a program address and receives the instruction word at that address in the same cycle. It splits the word into three 16-bit operand fields and a 16-bit control field. It then passes the decoded instruction to the execution units as a one-cycle issue pulse.

Two kinds of instruction keep the sequencer busy for more than one cycle. An idle instruction sleeps for a 32-bit count plus one cycle, and a memory transfer takes two cycles. During the extra cycles a stall output is raised, nothing is issued and the fetch address stays put. Branches take their destination from a register value, which the block reads through a register read port in the decode cycle. A conditional branch tests one selectable bit of a second register. Opcodes the block does not recognise run as one-cycle idles and set a flag that stays set until reset.

Top module: `flow_sequencer`

## Requirements
- R1: A synchronous active-high reset sets the fetch address to 0 and clears `iss_valid`, `stall_o` and `illegal_o`. The first issue follows on the first clock edge after reset is released.
- R2: In the decode cycle, `rd_x_idx` equals word bits [63:48] and `rd_y_idx` equals bits [47:32]. The issued fields are: `iss_x` = [63:48], `iss_y` = [47:32], `iss_z` = [31:16], `iss_bit` = [15:8], `iss_var` = [7:4] and `iss_opcode` = [3:0].
- R3: When an instruction does not take a branch, the next fetch address is the issued address plus 1.
- R4: Opcode 0 occupies N+1 cycles from its issue to the next issue, where N = {bits[47:32], bits[31:16]}. An all-zero word therefore takes 1 cycle, and N = 0x200 takes 513 cycles.
- R5: Opcode 3 (memory transfer) occupies exactly 2 cycles. Opcodes 2, 4, 5, 6 and 7 occupy 1 cycle.
- R6: `stall_o` is high in every extra cycle of an instruction and only then. It is never high together with `iss_valid`, and the fetch address does not change while it stays high.
- R7: Opcode 1 with variant 0 branches to the low 16 bits of the regX read value only when bit (bitI mod 64) of the regY read value is 1. Otherwise it steps by 1.
- R8: Opcode 1 with variant 1 always branches to the low 16 bits of the regX read value.
- R9: For opcode 2, `iss_imm` carries the 32-bit constant {bits[47:32], bits[31:16]}.
- R10: Opcodes 8 to 15, and opcode 1 with a variant of 2 or more, run as a 1-cycle step by 1 and set `illegal_o`. The flag stays high until reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| fetch_addr | output | 16 | Program address of the word being decoded |
| fetch_word | input | 64 | Instruction word at `fetch_addr`, same cycle |
| rd_x_idx | output | 16 | Register index for the branch target read |
| rd_y_idx | output | 16 | Register index for the branch condition read |
| rd_x_val | input | 64 | Value of register `rd_x_idx`, same cycle |
| rd_y_val | input | 64 | Value of register `rd_y_idx`, same cycle |
| iss_valid | output | 1 | One-cycle pulse: an instruction was issued |
| iss_pc | output | 16 | Address of the issued instruction |
| iss_opcode | output | 4 | Issued opcode |
| iss_var | output | 4 | Issued variant field |
| iss_bit | output | 8 | Issued bit-select field |
| iss_x | output | 16 | Issued regX field |
| iss_y | output | 16 | Issued regY field |
| iss_z | output | 16 | Issued regZ field |
| iss_imm | output | 32 | Constant formed from regY and regZ fields |
| stall_o | output | 1 | High in the extra cycles of a multi-cycle instruction |
| illegal_o | output | 1 | Sticky unrecognised-instruction flag |

## Verification
The assertions assume that the instruction memory and the register file answer in the same cycle. They check the branch target against the register value sampled one cycle before the issue pulse. They also assume that reset is the only event that can cut a sleep short. The stimulus keeps to these assumptions: the bench models both memories as combinational arrays indexed by the block's own outputs, and it raises reset only on a falling clock edge.

// File: rtl/flow_seq_pkg.sv
package flow_seq_pkg;

  localparam logic [3:0] OPC_IDLE   = 4'd0;
  localparam logic [3:0] OPC_BRANCH = 4'd1;
  localparam logic [3:0] OPC_CONST  = 4'd2;
  localparam logic [3:0] OPC_MEM    = 4'd3;
  localparam logic [3:0] OPC_LAST   = 4'd7;

  localparam logic [3:0] VAR_COND   = 4'd0;
  localparam logic [3:0] VAR_ALWAYS = 4'd1;

endpackage

// File: rtl/flow_decode.sv
module flow_decode
  import flow_seq_pkg::*;
#(
  parameter int FIELD_W = 16
) (
  input  logic [4*FIELD_W-1:0] word,
  output logic [FIELD_W-1:0]   f_x,
  output logic [FIELD_W-1:0]   f_y,
  output logic [FIELD_W-1:0]   f_z,
  output logic [FIELD_W/2-1:0] f_bit,
  output logic [3:0]           f_var,
  output logic [3:0]           f_op,
  output logic [2*FIELD_W-1:0] extra,
  output logic                 br_cond,
  output logic                 br_always,
  output logic                 bad_op
);

  always_comb begin
    f_x   = word[4*FIELD_W-1:3*FIELD_W];
    f_y   = word[3*FIELD_W-1:2*FIELD_W];
    f_z   = word[2*FIELD_W-1:FIELD_W];
    f_bit = word[FIELD_W-1:FIELD_W/2];
    f_var = word[7:4];
    f_op  = word[3:0];
  end

  always_comb begin
    extra     = '0;
    br_cond   = 1'b0;
    br_always = 1'b0;
    bad_op    = 1'b0;
    if (f_op > OPC_LAST) begin
      bad_op = 1'b1;
    end else begin
      case (f_op)
        OPC_IDLE: extra = {f_y, f_z};
        OPC_MEM:  extra = (2*FIELD_W)'(1);
        OPC_BRANCH: begin
          if (f_var == VAR_COND)        br_cond   = 1'b1;
          else if (f_var == VAR_ALWAYS) br_always = 1'b1;
          else                          bad_op    = 1'b1;
        end
        default: extra = '0;
      endcase
    end
  end

endmodule

// File: rtl/flow_hold_ctr.sv
module flow_hold_ctr #(
  parameter int CNT_W = 32
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [CNT_W-1:0] load_val,
  output logic             busy,
  output logic             stall_q
);

  logic [CNT_W-1:0] remain_q;

  assign busy = (remain_q != '0);

  always_ff @(posedge clk) begin
    if (rst) begin
      remain_q <= '0;
      stall_q  <= 1'b0;
    end else if (busy) begin
      remain_q <= remain_q - CNT_W'(1);
      stall_q  <= 1'b1;
    end else begin
      remain_q <= load_val;
      stall_q  <= 1'b0;
    end
  end

endmodule

// File: rtl/flow_pc_unit.sv
module flow_pc_unit #(
  parameter int PC_W = 16
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            advance,
  input  logic            take,
  input  logic [PC_W-1:0] target,
  output logic [PC_W-1:0] pc_q
);

  always_ff @(posedge clk) begin
    if (rst)          pc_q <= '0;
    else if (advance) pc_q <= take ? target : pc_q + PC_W'(1);
  end

endmodule

// File: rtl/flow_sequencer.sv
module flow_sequencer #(
  parameter int FIELD_W = 16,
  parameter int PC_W    = 16
) (
  input  logic                 clk,
  input  logic                 rst,
  output logic [PC_W-1:0]      fetch_addr,
  input  logic [4*FIELD_W-1:0] fetch_word,
  output logic [FIELD_W-1:0]   rd_x_idx,
  output logic [FIELD_W-1:0]   rd_y_idx,
  input  logic [4*FIELD_W-1:0] rd_x_val,
  input  logic [4*FIELD_W-1:0] rd_y_val,
  output logic                 iss_valid,
  output logic [PC_W-1:0]      iss_pc,
  output logic [3:0]           iss_opcode,
  output logic [3:0]           iss_var,
  output logic [FIELD_W/2-1:0] iss_bit,
  output logic [FIELD_W-1:0]   iss_x,
  output logic [FIELD_W-1:0]   iss_y,
  output logic [FIELD_W-1:0]   iss_z,
  output logic [2*FIELD_W-1:0] iss_imm,
  output logic                 stall_o,
  output logic                 illegal_o
);

  localparam int WORD_W    = 4 * FIELD_W;
  localparam int CNT_W     = 2 * FIELD_W;
  localparam int BIT_SEL_W = $clog2(WORD_W);

  logic [FIELD_W-1:0]   f_x, f_y, f_z;
  logic [FIELD_W/2-1:0] f_bit;
  logic [3:0]           f_var, f_op;
  logic [CNT_W-1:0]     extra;
  logic                 br_cond, br_always, bad_op;
  logic                 busy, go, cond_hit, take;

  flow_decode #(.FIELD_W(FIELD_W)) u_dec (
    .word      (fetch_word),
    .f_x       (f_x),
    .f_y       (f_y),
    .f_z       (f_z),
    .f_bit     (f_bit),
    .f_var     (f_var),
    .f_op      (f_op),
    .extra     (extra),
    .br_cond   (br_cond),
    .br_always (br_always),
    .bad_op    (bad_op)
  );

  flow_hold_ctr #(.CNT_W(CNT_W)) u_hold (
    .clk      (clk),
    .rst      (rst),
    .load_val (extra),
    .busy     (busy),
    .stall_q  (stall_o)
  );

  assign go       = !busy;
  assign cond_hit = rd_y_val[f_bit[BIT_SEL_W-1:0]];
  assign take     = br_always | (br_cond & cond_hit);

  flow_pc_unit #(.PC_W(PC_W)) u_pc (
    .clk     (clk),
    .rst     (rst),
    .advance (go),
    .take    (take),
    .target  (rd_x_val[PC_W-1:0]),
    .pc_q    (fetch_addr)
  );

  assign rd_x_idx = f_x;
  assign rd_y_idx = f_y;

  logic unused_bits;
  assign unused_bits = ^{rd_x_val[WORD_W-1:PC_W], f_bit[FIELD_W/2-1:BIT_SEL_W]};

  always_ff @(posedge clk) begin
    if (rst) begin
      iss_valid  <= 1'b0;
      iss_pc     <= '0;
      iss_opcode <= '0;
      iss_var    <= '0;
      iss_bit    <= '0;
      iss_x      <= '0;
      iss_y      <= '0;
      iss_z      <= '0;
      iss_imm    <= '0;
      illegal_o  <= 1'b0;
    end else begin
      iss_valid <= go;
      if (go) begin
        iss_pc     <= fetch_addr;
        iss_opcode <= f_op;
        iss_var    <= f_var;
        iss_bit    <= f_bit;
        iss_x      <= f_x;
        iss_y      <= f_y;
        iss_z      <= f_z;
        iss_imm    <= {f_y, f_z};
        if (bad_op) illegal_o <= 1'b1;
      end
    end
  end

endmodule

// File: rtl/flow_sequencer_chk.sv
module flow_sequencer_chk #(
  parameter int PC_W = 16
) (
  input logic            clk,
  input logic            rst,
  input logic [PC_W-1:0] fetch_addr,
  input logic [PC_W-1:0] x_tgt,
  input logic            iss_valid,
  input logic [PC_W-1:0] iss_pc,
  input logic [3:0]      iss_opcode,
  input logic [3:0]      iss_var,
  input logic            stall_o,
  input logic            illegal_o
);

  assert_reset_state_R1: assert property (@(posedge clk)
    $past(rst) |-> (!iss_valid && !stall_o && !illegal_o && fetch_addr == '0));

  assert_seq_step_R3: assert property (@(posedge clk) disable iff (rst)
    (iss_valid && (iss_opcode == 4'd2 || iss_opcode == 4'd3 || iss_opcode == 4'd4 ||
                   iss_opcode == 4'd5 || iss_opcode == 4'd6 || iss_opcode == 4'd7))
    |-> fetch_addr == iss_pc + PC_W'(1));

  assert_mem_two_R5: assert property (@(posedge clk) disable iff (rst)
    (iss_valid && iss_opcode == 4'd3) |=> (stall_o ##1 (iss_valid && !stall_o)));

  assert_issue_stall_excl_R6: assert property (@(posedge clk) disable iff (rst)
    !(iss_valid && stall_o));

  assert_fetch_hold_R6: assert property (@(posedge clk) disable iff (rst)
    (stall_o && $past(stall_o)) |-> $stable(fetch_addr));

  assert_jump_always_R8: assert property (@(posedge clk) disable iff (rst)
    (iss_valid && iss_opcode == 4'd1 && iss_var == 4'd1) |-> fetch_addr == $past(x_tgt));

  assert_illegal_sticky_R10: assert property (@(posedge clk) disable iff (rst)
    illegal_o |=> illegal_o);

endmodule

bind flow_sequencer flow_sequencer_chk #(.PC_W(PC_W)) u_chk (
  .clk        (clk),
  .rst        (rst),
  .fetch_addr (fetch_addr),
  .x_tgt      (rd_x_val[PC_W-1:0]),
  .iss_valid  (iss_valid),
  .iss_pc     (iss_pc),
  .iss_opcode (iss_opcode),
  .iss_var    (iss_var),
  .stall_o    (stall_o),
  .illegal_o  (illegal_o)
);

// File: tb/tb_flow_sequencer.sv
`timescale 1ns/1ps
module tb_flow_sequencer;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [15:0] fetch_addr;
  logic [63:0] fetch_word;
  logic [15:0] rd_x_idx, rd_y_idx;
  logic [63:0] rd_x_val, rd_y_val;
  logic        iss_valid;
  logic [15:0] iss_pc;
  logic [3:0]  iss_opcode, iss_var;
  logic [7:0]  iss_bit;
  logic [15:0] iss_x, iss_y, iss_z;
  logic [31:0] iss_imm;
  logic        stall_o, illegal_o;

  logic [63:0] rom  [64];
  logic [63:0] regs [16];

  int checks = 0;
  int errors = 0;
  bit done = 0;

  always #2 clk = ~clk;

  assign fetch_word = rom[fetch_addr[5:0]];
  assign rd_x_val   = regs[rd_x_idx[3:0]];
  assign rd_y_val   = regs[rd_y_idx[3:0]];

  flow_sequencer dut (
    .clk(clk), .rst(rst), .fetch_addr(fetch_addr), .fetch_word(fetch_word),
    .rd_x_idx(rd_x_idx), .rd_y_idx(rd_y_idx), .rd_x_val(rd_x_val), .rd_y_val(rd_y_val),
    .iss_valid(iss_valid), .iss_pc(iss_pc), .iss_opcode(iss_opcode), .iss_var(iss_var),
    .iss_bit(iss_bit), .iss_x(iss_x), .iss_y(iss_y), .iss_z(iss_z), .iss_imm(iss_imm),
    .stall_o(stall_o), .illegal_o(illegal_o)
  );

  // expected issue order and cycles from each issue to the next
  localparam int NSTEP = 12;
  localparam int EXP_PC [NSTEP] = '{0, 1, 2, 3, 4, 10, 11, 12, 20, 21, 0, 1};
  localparam int EXP_CY [NSTEP] = '{1, 4, 1, 2, 1, 1,  1,  1,  1,  1, 1, 4};

  task automatic chk(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic wait_issue(output int n);
    n = 0;
    do begin
      @(negedge clk);
      n++;
    end while (!iss_valid && n < 5000);
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst = 1'b1;
    repeat (2) @(negedge clk);
    chk(!iss_valid && !stall_o && !illegal_o && fetch_addr == 16'd0, "R1",
        {iss_valid, stall_o, illegal_o, fetch_addr}, 64'd0);
    rst = 1'b0;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog actual=%0h expected=%0h", 1, 0);
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    int n;
    int stall_bad;
    logic [15:0] held;
    for (int i = 0; i < 64; i++) rom[i] = 64'd0;
    for (int i = 0; i < 16; i++) regs[i] = 64'd0;
    regs[1] = 64'd10;
    regs[2] = 64'd4;
    regs[3] = 64'd20;
    regs[5] = 64'h8000_0000_0000_0000;
    rom[1]  = {16'h0000, 16'h0000, 16'h0003, 16'h0000};
    rom[2]  = {16'h0005, 16'h1234, 16'h5678, 16'h0002};
    rom[3]  = {16'h0007, 16'h0008, 16'h0000, 16'h0013};
    rom[4]  = {16'h0001, 16'h0002, 16'h0000, 16'h0201};
    rom[10] = {16'h0003, 16'h0002, 16'h0000, 16'h0301};
    rom[11] = {16'h0000, 16'h0000, 16'h0000, 16'h000F};
    rom[12] = {16'h0003, 16'h0000, 16'h0000, 16'h0011};
    rom[20] = {16'h0001, 16'h0002, 16'h0003, 16'h00B6};
    rom[21] = {16'h0006, 16'h0005, 16'h0000, 16'h3F01};

    do_reset();
    wait_issue(n);
    chk(n == 1, "R1 first issue", n, 1);

    for (int i = 0; i < NSTEP; i++) begin
      chk(iss_pc == 16'(EXP_PC[i]), "R3/R7/R8 issue order", iss_pc, EXP_PC[i]);
      if (i == 2) begin
        chk(iss_imm == 32'h1234_5678, "R9 constant", iss_imm, 32'h1234_5678);
        chk(iss_opcode == 4'd2 && iss_x == 16'd5 && iss_y == 16'h1234 && iss_z == 16'h5678,
            "R2 issued fields", {iss_opcode, iss_x, iss_y, iss_z}, {4'd2, 16'd5, 16'h1234, 16'h5678});
        chk(rd_x_idx == 16'd7 && rd_y_idx == 16'd8, "R2 read indices", {rd_x_idx, rd_y_idx}, {16'd7, 16'd8});
      end
      if (i == 3) chk(iss_var == 4'd1 && iss_opcode == 4'd3, "R2 variant field", {iss_var, iss_opcode}, 8'h13);
      if (i == 9) chk(iss_bit == 8'h3F, "R2 bit field", iss_bit, 8'h3F);
      if (i == 5) chk(!illegal_o, "R10 flag before", illegal_o, 0);
      if (i == 6) chk(illegal_o, "R10 flag set", illegal_o, 1);
      if (i == NSTEP - 1) chk(illegal_o, "R10 flag sticky", illegal_o, 1);
      stall_bad = 0;
      held = fetch_addr;
      n = 0;
      do begin
        @(negedge clk);
        n++;
        if (!iss_valid && (!stall_o || fetch_addr != held)) stall_bad++;
      end while (!iss_valid && n < 5000);
      chk(n == EXP_CY[i], "R4/R5 occupancy", n, EXP_CY[i]);
      chk(stall_bad == 0, "R6 stall and hold", stall_bad, 0);
    end

    // long sleep: count 0x200 gives 513 cycles
    rom[0] = {16'h0000, 16'h0000, 16'h0200, 16'h0000};
    do_reset();
    wait_issue(n);
    chk(iss_pc == 16'd0 && fetch_addr == 16'd1, "R4 long sleep start", {iss_pc, fetch_addr}, {16'd0, 16'd1});
    wait_issue(n);
    chk(n == 513, "R4 long sleep length", n, 513);

    // reset in the middle of a sleep
    do_reset();
    wait_issue(n);
    repeat (10) @(negedge clk);
    chk(stall_o && !iss_valid, "R6 mid sleep", {stall_o, iss_valid}, 2'b10);
    rst = 1'b1;
    @(negedge clk);
    chk(!stall_o && !iss_valid && fetch_addr == 16'd0, "R1 reset cuts sleep",
        {stall_o, iss_valid, fetch_addr}, 0);
    rst = 1'b0;

    done = 1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule